// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Port

This block is the control-register slave of a data converter. A host reaches it over three wires: a serial clock, an active-low chip select and one data line that both directions share. The pad is split into an input, an output and an output enable. The block samples all three wires with its own system clock, so the serial clock must run several times slower than that clock. Each frame opens with a 16-bit command word. One or more data bytes follow, and they go to or come from a small byte-wide register file. The address moves by one after every byte.

The register file holds the settings for the converter's output code format and its clock duty-cycle stabilizer, plus two general byte registers. If no frame has ever been seen since reset, the port counts as unused. The clock wire and the data wire are then static strap pins that set the format and the stabilizer directly. Once the first frame starts, the register contents drive those outputs. A configuration bit changes the bit order of later frames from most-significant-first to least-significant-first.

Top module: `spicfg_port`

## Requirements
- R1: The reset input loads every register with its default: 0x000 = 0x00, 0x001 = 0x00, 0x002 = 0x01, 0x003 = 0x00, 0x004 = 0x80.
- R2: The command word carries the read flag in bit 15 (1 = read), a byte-count code in bits 14:13 and a 13-bit register address in bits 12:0. Serial bits are taken on rising edges of the serial clock while chip select is low, and a frame begins when chip select falls.
- R3: Byte-count codes 00, 01 and 10 move exactly one, two and three data bytes. Any further bytes in the same frame change no register.
- R4: Byte-count code 11 keeps transferring bytes until chip select rises.
- R5: In most-significant-first frames the address goes up by one after each data byte.
- R6: The data output enable stays low during the command word and while chip select is high. It goes high after the 16th command bit of a read frame and stays high until chip select rises. Read data is shifted out one bit per serial clock rising edge.
- R7: Register bits outside the defined fields read as zero, whatever was written. The defined fields are 0x000 bit 1, 0x001 bits 1:0, 0x002 bit 0, 0x003 bits 3:0 and 0x004 bits 7:0. Addresses 0x005 and above read as zero and ignore writes.
- R8: Bit 1 of register 0x000 selects least-significant-first order, starting with the next frame. In that order the command word and the data bytes both travel LSB first, and the address goes down by one after each data byte.
- R9: If chip select rises before a byte is complete, that byte is not written.
- R10: Until the first frame after reset, `fmt_sel` is 01 (twos complement) when the clock wire is high and 00 (offset binary) when it is low, and `stab_en` follows the data wire.
- R11: After the first frame, `fmt_sel` shows register 0x001 bits 1:0 and `stab_en` shows register 0x002 bit 0.
- R12: The reset input also returns the port to the strap behaviour of R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, or format strap pin while the port is unused |
| spi_csb | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Data pad input, or stabilizer strap pin while the port is unused |
| sdio_o | output | 1 | Data pad output value for reads |
| sdio_oe | output | 1 | Data pad output enable |
| fmt_sel | output | 2 | Output code format: 00 offset binary, 01 twos complement, 10 Gray |
| stab_en | output | 1 | Duty-cycle stabilizer enable |

## Verification
The assertions run on every cycle and cover four things. The pad output is off whenever chip select has been high for more than one sampled cycle. Writes reach the register file only from inside a frame. A write to an unmapped address leaves the register image unchanged. Reset leaves the port unused with the pad released. The bench scenarios cover the rest: the byte-count codes, streaming, address stepping in both bit orders, masking of reserved bits, aborted bytes and the change from strap to register control. These need whole frames and readback of the stored values, so only the bench can check them.

// File: rtl/spicfg_pkg.sv
package spicfg_pkg;

    localparam int ADDR_W   = 13;
    localparam int BYTE_W   = 8;
    localparam int INSTR_W  = 16;
    localparam int NUM_REGS = 5;
    localparam int CNT_W    = 4;

    // register indices
    localparam int IDX_PORT = 0;
    localparam int IDX_FMT  = 1;
    localparam int IDX_CLK  = 2;
    localparam int IDX_TPAT = 3;
    localparam int IDX_GAIN = 4;

    localparam int LSB_BIT  = 1;

    typedef enum logic [1:0] {
        FMT_OFFSET = 2'b00,
        FMT_TWOS   = 2'b01,
        FMT_GRAY   = 2'b10
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INSTR,
        ST_DATA,
        ST_HOLD
    } fsm_e;

    typedef struct packed {
        logic              rd;
        logic [1:0]        cnt;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        case (idx)
            IDX_CLK:  return 8'h01;
            IDX_GAIN: return 8'h80;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] reg_mask(input int idx);
        case (idx)
            IDX_PORT: return 8'h02;
            IDX_FMT:  return 8'h03;
            IDX_CLK:  return 8'h01;
            IDX_TPAT: return 8'h0F;
            IDX_GAIN: return 8'hFF;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                    input logic down);
        return down ? a - 1'b1 : a + 1'b1;
    endfunction

    function automatic logic [INSTR_W-1:0] shift_word(input logic [INSTR_W-1:0] v,
                                                      input logic b, input logic lsb);
        return lsb ? {b, v[INSTR_W-1:1]} : {v[INSTR_W-2:0], b};
    endfunction

    function automatic logic [BYTE_W-1:0] shift_byte(input logic [BYTE_W-1:0] v,
                                                     input logic b, input logic lsb);
        return lsb ? {b, v[BYTE_W-1:1]} : {v[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/spicfg_sync.sv
module spicfg_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] dly
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_chan
            logic [STAGES:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= {(STAGES+1){RST_VAL[g]}};
                else     chain <= {chain[STAGES-1:0], d_in[g]};
            end
            assign lvl[g] = chain[STAGES-1];
            assign dly[g] = chain[STAGES];
        end
    endgenerate
endmodule

// File: rtl/spicfg_regs.sv
module spicfg_regs
    import spicfg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [BYTE_W-1:0]          rd_data,
    output logic                       lsb_first,
    output logic [1:0]                 fmt_cfg,
    output logic                       stab_cfg,
    output logic [NUM_REGS*BYTE_W-1:0] reg_image
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++)
                reg_image[i*BYTE_W +: BYTE_W] <= reg_default(i);
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++)
                if (wr_addr == ADDR_W'(i))
                    reg_image[i*BYTE_W +: BYTE_W] <= wr_data & reg_mask(i);
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == ADDR_W'(i))
                rd_data = reg_image[i*BYTE_W +: BYTE_W];
    end

    assign lsb_first = reg_image[IDX_PORT*BYTE_W + LSB_BIT];
    assign fmt_cfg   = reg_image[IDX_FMT*BYTE_W +: 2];
    assign stab_cfg  = reg_image[IDX_CLK*BYTE_W];
endmodule

// File: rtl/spicfg_frame.sv
module spicfg_frame
    import spicfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_rise,
    input  logic              csb_fall,
    input  logic              csb_rise,
    input  logic              din,
    input  logic              lsb_cfg,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              dout,
    output logic              dout_en,
    output logic              active
);
    fsm_e               st;
    logic [CNT_W-1:0]   bit_cnt;
    logic [INSTR_W-1:0] ins_q;
    logic [BYTE_W-1:0]  dsh;
    logic [ADDR_W-1:0]  addr_q;
    logic               rd_q;
    logic [1:0]         cnt_q;
    logic [1:0]         byte_q;
    logic               lsb_q;
    logic               load_q;

    logic [INSTR_W-1:0] ins_next;
    instr_t             ins_dec;
    logic [BYTE_W-1:0]  dat_next;
    logic               last_byte;

    assign ins_next  = shift_word(ins_q, din, lsb_q);
    assign ins_dec   = instr_t'(ins_next);
    assign dat_next  = shift_byte(dsh, din, lsb_q);
    assign last_byte = (cnt_q != 2'b11) && (byte_q == cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            ins_q   <= '0;
            dsh     <= '0;
            addr_q  <= '0;
            rd_q    <= 1'b0;
            cnt_q   <= '0;
            byte_q  <= '0;
            lsb_q   <= 1'b0;
            load_q  <= 1'b0;
            dout_en <= 1'b0;
            active  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en  <= 1'b0;
            load_q <= 1'b0;
            if (load_q) dsh <= rd_data;
            if (csb_rise) begin
                st      <= ST_IDLE;
                dout_en <= 1'b0;
            end else if (csb_fall) begin
                st      <= ST_INSTR;
                bit_cnt <= '0;
                byte_q  <= '0;
                lsb_q   <= lsb_cfg;
                active  <= 1'b1;
                dout_en <= 1'b0;
            end else if (sclk_rise) begin
                case (st)
                    ST_INSTR: begin
                        ins_q   <= ins_next;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == CNT_W'(INSTR_W-1)) begin
                            st      <= ST_DATA;
                            bit_cnt <= '0;
                            rd_q    <= ins_dec.rd;
                            cnt_q   <= ins_dec.cnt;
                            addr_q  <= ins_dec.addr;
                            if (ins_dec.rd) begin
                                dout_en <= 1'b1;
                                load_q  <= 1'b1;
                            end
                        end
                    end
                    ST_DATA: begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (rd_q) dsh <= shift_byte(dsh, 1'b0, lsb_q);
                        else      dsh <= dat_next;
                        if (bit_cnt == CNT_W'(BYTE_W-1)) begin
                            bit_cnt <= '0;
                            byte_q  <= byte_q + 1'b1;
                            addr_q  <= step_addr(addr_q, lsb_q);
                            if (!rd_q) begin
                                wr_en   <= 1'b1;
                                wr_addr <= addr_q;
                                wr_data <= dat_next;
                            end
                            if (last_byte) st <= ST_HOLD;
                            else if (rd_q) load_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_addr = addr_q;
    assign dout    = lsb_q ? dsh[0] : dsh[BYTE_W-1];
endmodule

// File: rtl/spicfg_port.sv
module spicfg_port
    import spicfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sclk,
    input  logic       spi_csb,
    input  logic       sdio_i,
    output logic       sdio_o,
    output logic       sdio_oe,
    output logic [1:0] fmt_sel,
    output logic       stab_en
);
    localparam int CH_SCLK = 0;
    localparam int CH_CSB  = 1;
    localparam int CH_DATA = 2;

    logic [2:0] lvl, dly;
    logic       csb_s, sclk_rise, csb_fall, csb_rise;
    logic       unused_dly;

    spicfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst(rst),
        .d_in({sdio_i, spi_csb, spi_sclk}),
        .lvl(lvl), .dly(dly)
    );

    assign csb_s      = lvl[CH_CSB];
    assign sclk_rise  = lvl[CH_SCLK] & ~dly[CH_SCLK];
    assign csb_fall   = ~lvl[CH_CSB] & dly[CH_CSB];
    assign csb_rise   = lvl[CH_CSB] & ~dly[CH_CSB];
    assign unused_dly = dly[CH_DATA];

    logic [ADDR_W-1:0]          rd_addr, wr_addr;
    logic [BYTE_W-1:0]          rd_data, wr_data;
    logic                       wr_en, lsb_first, stab_cfg, cfg_active;
    logic [1:0]                 fmt_cfg;
    logic [NUM_REGS*BYTE_W-1:0] reg_image;

    spicfg_frame u_frame (
        .clk(clk), .rst(rst),
        .sclk_rise(sclk_rise), .csb_fall(csb_fall), .csb_rise(csb_rise),
        .din(lvl[CH_DATA]), .lsb_cfg(lsb_first), .rd_data(rd_data),
        .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dout(sdio_o), .dout_en(sdio_oe), .active(cfg_active)
    );

    spicfg_regs u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .lsb_first(lsb_first), .fmt_cfg(fmt_cfg), .stab_cfg(stab_cfg),
        .reg_image(reg_image)
    );

    always_comb begin
        if (cfg_active) begin
            fmt_sel = fmt_cfg;
            stab_en = stab_cfg;
        end else begin
            fmt_sel = lvl[CH_SCLK] ? FMT_TWOS : FMT_OFFSET;
            stab_en = lvl[CH_DATA];
        end
    end
endmodule

// File: rtl/spicfg_port_chk.sv
module spicfg_port_chk
    import spicfg_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       csb_s,
    input logic                       sdio_oe,
    input logic                       cfg_active,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [NUM_REGS*BYTE_W-1:0] reg_image
);
    // pad released once chip select has stayed high
    assert_pad_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (csb_s && $past(csb_s)) |-> !sdio_oe);

    // a byte can only be committed from inside a frame
    assert_write_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !$past(csb_s));

    // unmapped addresses leave the storage untouched
    assert_unmapped_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr >= ADDR_W'(NUM_REGS))) |=> $stable(reg_image));

    // reset returns to strap mode with the pad released
    assert_reset_strap_R12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cfg_active && !sdio_oe));
endmodule

bind spicfg_port spicfg_port_chk u_chk (
    .clk(clk), .rst(rst), .csb_s(csb_s), .sdio_oe(sdio_oe),
    .cfg_active(cfg_active), .wr_en(wr_en), .wr_addr(wr_addr),
    .reg_image(reg_image)
);

// File: tb/spicfg_port_test.sv
module spicfg_port_test;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_csb = 1'b1;
    logic       sdio_i = 1'b0;
    logic       sdio_o, sdio_oe, stab_en;
    logic [1:0] fmt_sel;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spicfg_port uut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csb(spi_csb),
        .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
        .fmt_sel(fmt_sel), .stab_en(stab_en)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        sdio_i = b;
        tick(HALF);
        spi_sclk = 1'b1;
        tick(HALF);
        spi_sclk = 1'b0;
    endtask

    task automatic put_word(input logic [15:0] w, input logic lsb);
        for (int i = 0; i < 16; i++) put_bit(lsb ? w[i] : w[15-i]);
    endtask

    task automatic put_byte(input logic [7:0] v, input logic lsb);
        for (int i = 0; i < 8; i++) put_bit(lsb ? v[i] : v[7-i]);
    endtask

    task automatic get_byte(input logic lsb, output logic [7:0] v, output logic oe_all);
        oe_all = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(HALF);
            if (lsb) v[i] = sdio_o; else v[7-i] = sdio_o;
            oe_all &= sdio_oe;
            spi_sclk = 1'b1;
            tick(HALF);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic frame_start();
        spi_csb = 1'b0;
        tick(HALF);
    endtask

    task automatic frame_end();
        tick(HALF);
        spi_csb = 1'b1;
        sdio_i = 1'b0;
        tick(3*HALF);
    endtask

    task automatic write_frame(input logic lsb, input logic [1:0] w, input logic [12:0] a,
                               input int n, input logic [7:0] b0, input logic [7:0] b1,
                               input logic [7:0] b2);
        frame_start();
        put_word({1'b0, w, a}, lsb);
        if (n > 0) put_byte(b0, lsb);
        if (n > 1) put_byte(b1, lsb);
        if (n > 2) put_byte(b2, lsb);
        frame_end();
    endtask

    task automatic read_one(input logic lsb, input logic [12:0] a, output logic [7:0] v);
        logic oe;
        frame_start();
        put_word({1'b1, 2'b00, a}, lsb);
        get_byte(lsb, v, oe);
        frame_end();
    endtask

    task automatic t_reset_strap();
        chk("R12", "fmt after reset", fmt_sel, 0);
        chk("R12", "stab after reset", stab_en, 0);
        chk("R6", "oe after reset", sdio_oe, 0);
        spi_sclk = 1'b1; sdio_i = 1'b1;
        tick(6);
        chk("R10", "strap fmt clock high", fmt_sel, 1);
        chk("R10", "strap stab data high", stab_en, 1);
        spi_sclk = 1'b0;
        tick(6);
        chk("R10", "strap fmt clock low", fmt_sel, 0);
        sdio_i = 1'b0;
        tick(6);
    endtask

    task automatic t_defaults_stream();
        logic [7:0] exp [6] = '{8'h00, 8'h00, 8'h01, 8'h00, 8'h80, 8'h00};
        logic [7:0] v;
        logic oe;
        logic [15:0] cmd = {1'b1, 2'b11, 13'h0000};
        frame_start();
        for (int i = 0; i < 15; i++) put_bit(cmd[15-i]);
        chk("R6", "oe during command", sdio_oe, 0);
        put_bit(cmd[0]);
        for (int k = 0; k < 6; k++) begin
            get_byte(1'b0, v, oe);
            chk("R1", $sformatf("default/stream byte %0d (R4 R5)", k), v, exp[k]);
            chk("R6", $sformatf("oe in data byte %0d", k), oe, 1);
        end
        frame_end();
        chk("R6", "oe after chip select high", sdio_oe, 0);
        chk("R11", "fmt from register", fmt_sel, 0);
        chk("R11", "stab from register", stab_en, 1);
    endtask

    task automatic t_single_write();
        logic [7:0] v;
        write_frame(1'b0, 2'b00, 13'h0003, 2, 8'hFF, 8'h55, 8'h00);
        read_one(1'b0, 13'h0003, v);
        chk("R7", "reserved bits of 0x003", v, 8'h0F);
        read_one(1'b0, 13'h0004, v);
        chk("R3", "byte beyond count ignored", v, 8'h80);
    endtask

    task automatic t_multi_write();
        logic [7:0] v;
        write_frame(1'b0, 2'b01, 13'h0001, 2, 8'h01, 8'h00, 8'h00);
        chk("R11", "fmt after write", fmt_sel, 1);
        chk("R3", "two bytes reached 0x002", stab_en, 0);
        write_frame(1'b0, 2'b10, 13'h0002, 3, 8'h01, 8'h0A, 8'h33);
        read_one(1'b0, 13'h0002, v);
        chk("R3", "three bytes first", v, 8'h01);
        read_one(1'b0, 13'h0003, v);
        chk("R5", "three bytes second", v, 8'h0A);
        read_one(1'b0, 13'h0004, v);
        chk("R2", "three bytes third", v, 8'h33);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        write_frame(1'b0, 2'b00, 13'h0010, 1, 8'hAA, 8'h00, 8'h00);
        read_one(1'b0, 13'h0010, v);
        chk("R7", "unmapped reads zero", v, 0);
        read_one(1'b0, 13'h0004, v);
        chk("R7", "unmapped write no side effect", v, 8'h33);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        frame_start();
        put_word({1'b0, 2'b00, 13'h0004}, 1'b0);
        for (int i = 0; i < 5; i++) put_bit(1'b1);
        frame_end();
        read_one(1'b0, 13'h0004, v);
        chk("R9", "aborted byte not written", v, 8'h33);
    endtask

    task automatic t_lsb_first();
        logic [7:0] v;
        logic oe;
        write_frame(1'b0, 2'b00, 13'h0000, 1, 8'h02, 8'h00, 8'h00);
        write_frame(1'b1, 2'b01, 13'h0004, 2, 8'h5A, 8'h3C, 8'h00);
        frame_start();
        put_word({1'b1, 2'b01, 13'h0004}, 1'b1);
        get_byte(1'b1, v, oe);
        chk("R8", "lsb read first byte", v, 8'h5A);
        get_byte(1'b1, v, oe);
        chk("R8", "lsb read decremented byte", v, 8'h0C);
        frame_end();
        write_frame(1'b1, 2'b00, 13'h0000, 1, 8'h00, 8'h00, 8'h00);
        read_one(1'b0, 13'h0000, v);
        chk("R8", "back to msb order", v, 8'h00);
    endtask

    task automatic t_reset_again();
        logic [7:0] v;
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(4);
        chk("R12", "strap fmt after second reset", fmt_sel, 0);
        chk("R12", "strap stab after second reset", stab_en, 0);
        read_one(1'b0, 13'h0004, v);
        chk("R1", "default restored by reset", v, 8'h80);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(4);
        t_reset_strap();
        t_defaults_stream();
        t_single_write();
        t_multi_write();
        t_unmapped();
        t_abort();
        t_lsb_first();
        t_reset_again();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule